// File: doc/BRIEF.md
# Effective Address Generation Unit

This block resolves the operand of a decoded instruction. It is given an address field taken from the instruction word, a 4-bit mode code, a register selector and the current program counter. From these it produces the effective address, the operand value and a tag that says where the operand came from: the instruction itself, a register, or memory. Modes that need memory go through a single read port with a request/acknowledge handshake. A mode may need zero, one or two reads.

The unit holds its own file of general-purpose registers, written through a plain write port. The highest-numbered register doubles as the stack pointer. Each operation starts with a one-cycle `start_i` pulse and ends with a one-cycle `done_o` pulse. Starts that arrive while the unit is busy are not taken. When enabled, the two index-through-memory modes advance their index register by one on the cycle that `done_o` rises.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done_o`, `mem_req_o` and `busy_o` are low and every register reads as zero.
- R2: Mode 0 (immediate) sign-extends the field to the word width. Both `operand_o` and `ea_o` carry that value. `src_o` is 0 (instruction), no memory read is made, and `done_o` rises in the cycle after `start_i` is sampled.
- R3: Mode 1 (direct) uses the zero-extended field as `ea_o`. It makes exactly one read and returns the word read as `operand_o` with `src_o` = 2 (memory).
- R4: Mode 2 (indirect) reads memory at the zero-extended field. The word returned becomes `ea_o`, and a second read at that address supplies `operand_o`.
- R5: Mode 3 (register) returns the selected register as `operand_o` and the selector, zero-extended, as `ea_o`. `src_o` is 1 and no read is made. Mode 4 (register indirect) takes `ea_o` from the selected register and makes one read.
- R6: Mode 5 (displacement) uses register + zero-extended field as `ea_o`. Mode 7 (base) uses register + sign-extended field. Both wrap modulo 2^WORD_W and make one read.
- R7: Mode 6 (PC-relative) uses `pc_i` + sign-extended field as `ea_o` and makes one read.
- R8: Mode 8 (pre-index) reads memory at field + register, and the word returned is `ea_o`. Mode 9 (post-index) reads memory at the field and adds the register to the word returned to form `ea_o`. Each then reads the operand, for two reads in total.
- R9: Mode 10 (stack) uses register NREG-1 as `ea_o` and makes one read.
- R10: Mode codes 11 to 15 raise `illegal_o` together with `done_o`, set `src_o` = 3, `ea_o` = 0 and `operand_o` = 0, and make no memory read.
- R11: With AUTOINC_EN set, modes 8 and 9 increment the selected register by one on the cycle `done_o` rises. The post-index address uses the value from before the increment.
- R12: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_ack_i`. `mem_rdata_i` is taken on the cycle `mem_ack_i` is high.
- R13: `done_o` lasts one cycle. `busy_o` is high from the cycle after a memory mode starts until `done_o`, and is low while `done_o` is high.
- R14: When `wr_en_i` is high, `wr_data_i` is written into register `wr_idx_i` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation |
| mode_i | input | 4 | Addressing mode code |
| field_i | input | FIELD_W | Address field from the instruction |
| reg_sel_i | input | IDX_W | Register selector |
| pc_i | input | WORD_W | Program counter |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | IDX_W | Register write index |
| wr_data_i | input | WORD_W | Register write data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | WORD_W | Memory read address |
| mem_ack_i | input | 1 | Read data valid |
| mem_rdata_i | input | WORD_W | Read data |
| done_o | output | 1 | Operation complete pulse |
| illegal_o | output | 1 | Unused mode code, with done |
| src_o | output | 2 | 0 instruction, 1 register, 2 memory, 3 none |
| ea_o | output | WORD_W | Effective address |
| operand_o | output | WORD_W | Operand value |
| busy_o | output | 1 | Operation in progress |

## Verification
Every one of the sixteen mode codes is run with five field values: zero, the largest positive value, the most negative value, all ones, and a mid-range value. Each combination uses three registers: one that is zero, one near the top of the word so that additions wrap, and the stack pointer. The negative fields tell sign extension apart from zero extension, which separates base from displacement and sizes the PC-relative offsets. The wrapping register exposes carry handling. Counting reads per operation tells the direct and indirect paths apart, and the order of the pre-index and post-index steps. Reading the registers back in register mode after the index modes checks the auto-increment and the write port.

// File: rtl/eau_pkg.sv
package eau_pkg;

   localparam logic [3:0] MD_IMM    = 4'd0;
   localparam logic [3:0] MD_DIR    = 4'd1;
   localparam logic [3:0] MD_IND    = 4'd2;
   localparam logic [3:0] MD_REG    = 4'd3;
   localparam logic [3:0] MD_RIND   = 4'd4;
   localparam logic [3:0] MD_DISP   = 4'd5;
   localparam logic [3:0] MD_PCREL  = 4'd6;
   localparam logic [3:0] MD_BASE   = 4'd7;
   localparam logic [3:0] MD_PREIX  = 4'd8;
   localparam logic [3:0] MD_POSTIX = 4'd9;
   localparam logic [3:0] MD_STACK  = 4'd10;

   typedef enum logic [1:0] {
      SRC_INSN = 2'd0,
      SRC_REG  = 2'd1,
      SRC_MEM  = 2'd2,
      SRC_NONE = 2'd3
   } eau_src_e;

   typedef struct packed {
      logic     illegal;
      logic     need_mem;
      logic     two_step;
      logic     post_add;
      logic     idx_mode;
      eau_src_e src;
   } eau_plan_t;

   function automatic eau_plan_t eau_decode(input logic [3:0] m);
      eau_plan_t p;
      p = '{illegal: 1'b0, need_mem: 1'b1, two_step: 1'b0, post_add: 1'b0,
            idx_mode: 1'b0, src: SRC_MEM};
      case (m)
         MD_IMM:    begin p.need_mem = 1'b0; p.src = SRC_INSN; end
         MD_REG:    begin p.need_mem = 1'b0; p.src = SRC_REG; end
         MD_IND:    p.two_step = 1'b1;
         MD_PREIX:  begin p.two_step = 1'b1; p.idx_mode = 1'b1; end
         MD_POSTIX: begin p.two_step = 1'b1; p.idx_mode = 1'b1; p.post_add = 1'b1; end
         MD_DIR, MD_RIND, MD_DISP, MD_PCREL, MD_BASE, MD_STACK: ;
         default:   begin p.illegal = 1'b1; p.need_mem = 1'b0; p.src = SRC_NONE; end
      endcase
      return p;
   endfunction

endpackage

// File: rtl/eau_regfile.sv
module eau_regfile #(
   parameter int WORD_W = 16,
   parameter int NREG   = 8,
   parameter int IDX_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic              inc_en_i,
   input  logic [IDX_W-1:0]  inc_idx_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [WORD_W-1:0] rd_data_o,
   output logic [WORD_W-1:0] sp_data_o
);

   logic [WORD_W-1:0] reg_arr [NREG];

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [WORD_W-1:0] val_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            val_q <= '0;
         else if (wr_en_i && (wr_idx_i == IDX_W'(r)))
            val_q <= wr_data_i;
         else if (inc_en_i && (inc_idx_i == IDX_W'(r)))
            val_q <= val_q + WORD_W'(1);
      end
      assign reg_arr[r] = val_q;
   end

   assign rd_data_o = reg_arr[rd_idx_i];
   assign sp_data_o = reg_arr[NREG-1];

endmodule

// File: rtl/eau_addr_calc.sv
module eau_addr_calc
   import eau_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int FIELD_W = 8,
   parameter int IDX_W   = 3
) (
   input  logic [3:0]         mode_i,
   input  logic [FIELD_W-1:0] field_i,
   input  logic [IDX_W-1:0]   sel_i,
   input  logic [WORD_W-1:0]  reg_val_i,
   input  logic [WORD_W-1:0]  sp_val_i,
   input  logic [WORD_W-1:0]  pc_i,
   output eau_plan_t          plan_o,
   output logic [WORD_W-1:0]  addr1_o,
   output logic [WORD_W-1:0]  nomem_ea_o,
   output logic [WORD_W-1:0]  nomem_op_o
);

   localparam int EXT_W = WORD_W - FIELD_W;
   localparam int SEL_PAD = WORD_W - IDX_W;

   logic [WORD_W-1:0] field_sx, field_zx, sel_zx;

   assign field_sx = {{EXT_W{field_i[FIELD_W-1]}}, field_i};
   assign field_zx = {{EXT_W{1'b0}}, field_i};
   assign sel_zx   = {{SEL_PAD{1'b0}}, sel_i};
   assign plan_o   = eau_decode(mode_i);

   always_comb begin
      case (mode_i)
         MD_DIR, MD_IND, MD_POSTIX: addr1_o = field_zx;
         MD_RIND:                   addr1_o = reg_val_i;
         MD_DISP, MD_PREIX:         addr1_o = reg_val_i + field_zx;
         MD_PCREL:                  addr1_o = pc_i + field_sx;
         MD_BASE:                   addr1_o = reg_val_i + field_sx;
         MD_STACK:                  addr1_o = sp_val_i;
         default:                   addr1_o = '0;
      endcase
   end

   always_comb begin
      if (mode_i == MD_REG) begin
         nomem_ea_o = sel_zx;
         nomem_op_o = reg_val_i;
      end else begin
         nomem_ea_o = field_sx;
         nomem_op_o = field_sx;
      end
   end

endmodule

// File: rtl/eau_seq.sv
module eau_seq
   import eau_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  eau_plan_t         plan_i,
   input  logic [WORD_W-1:0] addr1_i,
   input  logic [WORD_W-1:0] nomem_ea_i,
   input  logic [WORD_W-1:0] nomem_op_i,
   input  logic [WORD_W-1:0] reg_val_i,
   input  logic [IDX_W-1:0]  sel_i,
   input  logic              mem_ack_i,
   input  logic [WORD_W-1:0] mem_rdata_i,
   output logic              mem_req_o,
   output logic [WORD_W-1:0] mem_addr_o,
   output logic              done_o,
   output logic              illegal_o,
   output logic [1:0]        src_o,
   output logic [WORD_W-1:0] ea_o,
   output logic [WORD_W-1:0] operand_o,
   output logic              busy_o,
   output logic              inc_req_o,
   output logic [IDX_W-1:0]  inc_idx_o
);

   typedef enum logic [1:0] {ST_IDLE, ST_ACC1, ST_ACC2} st_e;

   st_e               st_q;
   logic              req_q, done_q, ill_q, two_q, post_q, idxm_q;
   logic [WORD_W-1:0] addr_q, ea_q, op_q, idxv_q;
   logic [IDX_W-1:0]  sel_q;
   eau_src_e          src_q;
   logic              final_ack;

   assign final_ack = mem_ack_i &&
                      ((st_q == ST_ACC2) || ((st_q == ST_ACC1) && !two_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         req_q  <= 1'b0;
         done_q <= 1'b0;
         ill_q  <= 1'b0;
         two_q  <= 1'b0;
         post_q <= 1'b0;
         idxm_q <= 1'b0;
         addr_q <= '0;
         ea_q   <= '0;
         op_q   <= '0;
         idxv_q <= '0;
         sel_q  <= '0;
         src_q  <= SRC_INSN;
      end else begin
         done_q <= 1'b0;
         ill_q  <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  sel_q  <= sel_i;
                  idxv_q <= reg_val_i;
                  two_q  <= plan_i.two_step;
                  post_q <= plan_i.post_add;
                  idxm_q <= plan_i.idx_mode;
                  if (plan_i.illegal) begin
                     done_q <= 1'b1;
                     ill_q  <= 1'b1;
                     src_q  <= SRC_NONE;
                     ea_q   <= '0;
                     op_q   <= '0;
                  end else if (!plan_i.need_mem) begin
                     done_q <= 1'b1;
                     src_q  <= plan_i.src;
                     ea_q   <= nomem_ea_i;
                     op_q   <= nomem_op_i;
                  end else begin
                     req_q  <= 1'b1;
                     addr_q <= addr1_i;
                     st_q   <= ST_ACC1;
                  end
               end
            end
            ST_ACC1, ST_ACC2: begin
               if (final_ack) begin
                  req_q  <= 1'b0;
                  done_q <= 1'b1;
                  src_q  <= SRC_MEM;
                  ea_q   <= addr_q;
                  op_q   <= mem_rdata_i;
                  st_q   <= ST_IDLE;
               end else if (mem_ack_i) begin
                  addr_q <= post_q ? (mem_rdata_i + idxv_q) : mem_rdata_i;
                  st_q   <= ST_ACC2;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_o  = req_q;
   assign mem_addr_o = addr_q;
   assign done_o     = done_q;
   assign illegal_o  = ill_q;
   assign src_o      = src_q;
   assign ea_o       = ea_q;
   assign operand_o  = op_q;
   assign busy_o     = (st_q != ST_IDLE);
   assign inc_req_o  = final_ack && idxm_q;
   assign inc_idx_o  = sel_q;

endmodule

// File: rtl/ea_unit.sv
module ea_unit
   import eau_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int FIELD_W    = 8,
   parameter int NREG       = 8,
   parameter int AUTOINC_EN = 1,
   localparam int IDX_W     = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [3:0]         mode_i,
   input  logic [FIELD_W-1:0] field_i,
   input  logic [IDX_W-1:0]   reg_sel_i,
   input  logic [WORD_W-1:0]  pc_i,
   input  logic               wr_en_i,
   input  logic [IDX_W-1:0]   wr_idx_i,
   input  logic [WORD_W-1:0]  wr_data_i,
   output logic               mem_req_o,
   output logic [WORD_W-1:0]  mem_addr_o,
   input  logic               mem_ack_i,
   input  logic [WORD_W-1:0]  mem_rdata_i,
   output logic               done_o,
   output logic               illegal_o,
   output logic [1:0]         src_o,
   output logic [WORD_W-1:0]  ea_o,
   output logic [WORD_W-1:0]  operand_o,
   output logic               busy_o
);

   if (FIELD_W >= WORD_W) begin : g_bad_field
      $error("ea_unit: FIELD_W must be narrower than WORD_W");
   end
   if ((NREG < 2) || (NREG != (1 << IDX_W))) begin : g_bad_nreg
      $error("ea_unit: NREG must be a power of two of at least 2");
   end
   if (IDX_W >= WORD_W) begin : g_bad_idx
      $error("ea_unit: register selector wider than the word");
   end

   eau_plan_t         plan;
   logic [WORD_W-1:0] reg_val, sp_val, addr1, nomem_ea, nomem_op;
   logic              inc_req, inc_en;
   logic [IDX_W-1:0]  inc_idx;

   eau_regfile #(.WORD_W(WORD_W), .NREG(NREG), .IDX_W(IDX_W)) rf_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
      .inc_en_i(inc_en), .inc_idx_i(inc_idx),
      .rd_idx_i(reg_sel_i), .rd_data_o(reg_val), .sp_data_o(sp_val)
   );

   eau_addr_calc #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) calc_i (
      .mode_i(mode_i), .field_i(field_i), .sel_i(reg_sel_i),
      .reg_val_i(reg_val), .sp_val_i(sp_val), .pc_i(pc_i),
      .plan_o(plan), .addr1_o(addr1), .nomem_ea_o(nomem_ea), .nomem_op_o(nomem_op)
   );

   eau_seq #(.WORD_W(WORD_W), .IDX_W(IDX_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .plan_i(plan),
      .addr1_i(addr1), .nomem_ea_i(nomem_ea), .nomem_op_i(nomem_op),
      .reg_val_i(reg_val), .sel_i(reg_sel_i),
      .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
      .done_o(done_o), .illegal_o(illegal_o), .src_o(src_o),
      .ea_o(ea_o), .operand_o(operand_o), .busy_o(busy_o),
      .inc_req_o(inc_req), .inc_idx_o(inc_idx)
   );

   if (AUTOINC_EN != 0) begin : g_autoinc
      assign inc_en = inc_req;
   end else begin : g_no_autoinc
      assign inc_en = 1'b0 & inc_req;
   end

endmodule

// File: rtl/eau_checker.sv
module eau_checker #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic              illegal_o,
   input logic              mem_req_o,
   input logic              mem_ack_i,
   input logic [WORD_W-1:0] mem_addr_o,
   input logic [1:0]        src_o
);

   // R13: completion strobe is a single cycle
   a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R12: request and address held until acknowledged
   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

   // R10: illegal codes finish at once with no read and no source
   a_r10_illegal_nomem: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (done_o && !mem_req_o && (src_o == 2'd3)));

   // R13: unit is idle when it reports completion
   a_r13_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !mem_req_o));

   // R12: a request only exists during an operation
   a_r12_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> busy_o);

   // R3: an operation that went through memory reports a memory source
   a_r3_mem_src: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(busy_o)) |-> (src_o == 2'd2));

endmodule

bind ea_unit eau_checker #(.WORD_W(WORD_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
   .illegal_o(illegal_o), .mem_req_o(mem_req_o), .mem_ack_i(mem_ack_i),
   .mem_addr_o(mem_addr_o), .src_o(src_o)
);

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;

   localparam int W = 16;
   localparam int F = 8;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         start_i;
   logic [3:0]   mode_i;
   logic [F-1:0] field_i;
   logic [2:0]   reg_sel_i;
   logic [W-1:0] pc_i;
   logic         wr_en_i;
   logic [2:0]   wr_idx_i;
   logic [W-1:0] wr_data_i;
   logic         mem_req_o;
   logic [W-1:0] mem_addr_o;
   logic         mem_ack_i;
   logic [W-1:0] mem_rdata_i;
   logic         done_o, illegal_o, busy_o;
   logic [1:0]   src_o;
   logic [W-1:0] ea_o, operand_o;

   int tests = 0;
   int fails = 0;
   int acc_cnt = 0;
   logic [W-1:0] rm [N];

   always #5 clk = ~clk;

   ea_unit #(.WORD_W(W), .FIELD_W(F), .NREG(N), .AUTOINC_EN(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .field_i(field_i), .reg_sel_i(reg_sel_i), .pc_i(pc_i),
      .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
      .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
      .done_o(done_o), .illegal_o(illegal_o), .src_o(src_o),
      .ea_o(ea_o), .operand_o(operand_o), .busy_o(busy_o)
   );

   function automatic logic [W-1:0] memf(input logic [W-1:0] a);
      logic [W-1:0] p;
      p = a * 16'h9E37;
      return p ^ 16'h5A5A;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // memory model: acknowledges one half cycle after a request is seen
   initial begin
      mem_ack_i   = 1'b0;
      mem_rdata_i = '0;
      forever begin
         @(negedge clk);
         if (mem_ack_i) mem_ack_i = 1'b0;
         else if (mem_req_o) begin
            mem_ack_i   = 1'b1;
            mem_rdata_i = memf(mem_addr_o);
            acc_cnt++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: got %h expected %h", 16'h0, 16'h1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic wr_reg(input int idx, input logic [W-1:0] val);
      @(negedge clk);
      wr_en_i   = 1'b1;
      wr_idx_i  = 3'(idx);
      wr_data_i = val;
      @(negedge clk);
      wr_en_i = 1'b0;
      rm[idx] = val;
   endtask

   task automatic do_op(input int m, input logic [F-1:0] f, input int sel,
                        input logic [W-1:0] pcv);
      logic [W-1:0] sx, zx, e_ea, e_op, rv;
      logic [1:0]   e_src;
      int           e_acc, a0, cyc;
      bit           e_ill, inc;
      string        tag;
      sx = {{(W-F){f[F-1]}}, f};
      zx = {{(W-F){1'b0}}, f};
      rv = rm[sel];
      e_ill = 1'b0; inc = 1'b0; e_src = 2'd2; e_acc = 1; e_op = '0;
      case (m)
         0:  begin tag = "R2";  e_ea = sx; e_op = sx; e_src = 2'd0; e_acc = 0; end
         1:  begin tag = "R3";  e_ea = zx; end
         2:  begin tag = "R4";  e_ea = memf(zx); e_acc = 2; end
         3:  begin tag = "R5";  e_ea = W'(sel); e_op = rv; e_src = 2'd1; e_acc = 0; end
         4:  begin tag = "R5";  e_ea = rv; end
         5:  begin tag = "R6";  e_ea = rv + zx; end
         6:  begin tag = "R7";  e_ea = pcv + sx; end
         7:  begin tag = "R6";  e_ea = rv + sx; end
         8:  begin tag = "R8";  e_ea = memf(zx + rv); e_acc = 2; inc = 1'b1; end
         9:  begin tag = "R8";  e_ea = memf(zx) + rv; e_acc = 2; inc = 1'b1; end
         10: begin tag = "R9";  e_ea = rm[N-1]; end
         default: begin tag = "R10"; e_ea = '0; e_src = 2'd3; e_acc = 0; e_ill = 1'b1; end
      endcase
      if (e_src == 2'd2) e_op = memf(e_ea);
      a0 = acc_cnt;
      @(negedge clk);
      start_i = 1'b1; mode_i = 4'(m); field_i = f; reg_sel_i = 3'(sel); pc_i = pcv;
      @(negedge clk);
      start_i = 1'b0;
      if (e_acc == 0)
         chk(done_o == 1'b1, {tag, " done one cycle after start (R2)"}, W'(done_o), 16'h1);
      else
         chk(busy_o == 1'b1, {tag, " busy during access R13"}, W'(busy_o), 16'h1);
      cyc = 0;
      while (!done_o && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
      chk(done_o == 1'b1, {tag, " done reached"}, W'(done_o), 16'h1);
      chk(ea_o == e_ea, {tag, " ea"}, ea_o, e_ea);
      chk(operand_o == e_op, {tag, " operand"}, operand_o, e_op);
      chk(src_o == e_src, {tag, " source tag"}, W'(src_o), W'(e_src));
      chk(illegal_o == e_ill, {tag, " illegal flag R10"}, W'(illegal_o), W'(e_ill));
      chk(busy_o == 1'b0, {tag, " idle at done R13"}, W'(busy_o), 16'h0);
      chk((acc_cnt - a0) == e_acc, {tag, " read count R12"}, W'(acc_cnt - a0), W'(e_acc));
      @(negedge clk);
      chk(done_o == 1'b0, {tag, " done pulse R13"}, W'(done_o), 16'h0);
      if (inc) rm[sel] = rm[sel] + 1'b1; // R11 model
   endtask

   initial begin
      rst_n = 1'b0; start_i = 1'b0; mode_i = '0; field_i = '0; reg_sel_i = '0;
      pc_i = '0; wr_en_i = 1'b0; wr_idx_i = '0; wr_data_i = '0;
      for (int i = 0; i < N; i++) rm[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done_o == 1'b0, "R1 done after reset", W'(done_o), 16'h0);
      chk(mem_req_o == 1'b0, "R1 req after reset", W'(mem_req_o), 16'h0);
      chk(busy_o == 1'b0, "R1 busy after reset", W'(busy_o), 16'h0);
      for (int s = 0; s < N; s++) do_op(3, 8'h00, s, 16'h0); // R1 registers zero

      wr_reg(0, 16'h0000);
      wr_reg(2, 16'hFFF0);
      wr_reg(7, 16'h3A00);
      wr_reg(5, 16'hBEEF);
      do_op(3, 8'h11, 5, 16'h0); // R14 write port read back

      for (int m = 0; m < 16; m++)
         for (int fi = 0; fi < 5; fi++)
            for (int si = 0; si < 3; si++) begin
               logic [F-1:0] f;
               int sel;
               case (fi)
                  0: f = 8'h00;
                  1: f = 8'h7F;
                  2: f = 8'h80;
                  3: f = 8'hFF;
                  default: f = 8'h35;
               endcase
               sel = (si == 0) ? 0 : ((si == 1) ? 2 : 7);
               do_op(m, f, sel, 16'h0100 + 16'(m * 3));
            end

      // R11: index register advanced by the index modes, read back via register mode
      wr_reg(4, 16'h0040);
      do_op(8, 8'h10, 4, 16'h0);
      do_op(9, 8'h10, 4, 16'h0);
      do_op(3, 8'h00, 4, 16'h0);
      chk(rm[4] == 16'h0042, "R11 model after two index ops", rm[4], 16'h0042);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule